// File: doc/BRIEF.md
# Checkstop Capture Controller

This block collects error indications from a set of processor units and decides whether any of them must stop the core for good. A qualified error puts the core into checkstop: a halt output rises first, and a freeze output follows to stop every capture of state so the frozen contents can be examined later. Only a reset brings the core out of checkstop.

Software controls the block through one 32-bit special-purpose register, reached at register number 1008 over a simple access port and only at supervisor privilege. The register numbers its bits from the most significant end: bit 0 is the word's MSB. It holds a master enable, one sticky cause bit per source, and a field of per-source enable bits. Source k reports through cause bit 1+k and is enabled by bit 16+k. Source 0 is the machine-check condition, which also depends on the machine-check-enable flag of the machine state register.

Top module: `checkstop_ctrl`

## Requirements
- R1: While the master enable (bit 0, the word's MSB) is 0, no source can start a checkstop and halt_o stays low.
- R2: With the master enable set, an asserted source whose enable bit (bit 16+k for source k) is 1 is taken at the clock edge that samples it, and halt_o is high from the next cycle on; a source whose enable bit is 0 is ignored.
- R3: freeze_o rises exactly one cycle after halt_o rises, and both then stay high until reset.
- R4: Cause bit 1+k is set for every qualified source k active at the taking edge, and for no other; causes never change afterwards, and writes never set or clear them.
- R5: The machine-check source (source 0) qualifies only when msr_me_i is 0 and bit 16 is 1; with msr_me_i high it never starts a checkstop.
- R6: After reset the register reads 0x00010080 (only enable bits 15 and 24 set), and halt_o and freeze_o are low.
- R7: A supervisor write loads bit 0 and bits 15 to 31 from the write data; bits 12 to 14 always read 0.
- R8: Accesses carrying any register number other than 1008 change nothing, read 0 and raise no privilege error.
- R9: An access at user privilege to register 1008 leaves the register unchanged, reads 0, and drives priv_err_o high in the same cycle.
- R10: From the cycle halt_o is high, writes to the register have no effect.
- R11: When a write and a taken checkstop share a clock edge, the decision uses the register contents from before the write, and the write is still applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | NUM_SRC | Error conditions from the units; bit 0 is machine check |
| msr_me_i | input | 1 | Machine-check-enable flag of the machine state register |
| spr_valid_i | input | 1 | Register access request this cycle |
| spr_we_i | input | 1 | 1 for a write, 0 for a read |
| spr_num_i | input | SPR_NUM_W | Special-purpose register number of the access |
| spr_sup_i | input | 1 | 1 when the access runs at supervisor privilege |
| spr_wdata_i | input | 32 | Write data, bit 0 in the MSB |
| spr_rdata_o | output | 32 | Read data, 0 unless a supervisor read of register 1008 |
| priv_err_o | output | 1 | User-privilege access to register 1008 |
| halt_o | output | 1 | Instruction processing stopped |
| freeze_o | output | 1 | All state capture stopped |

## Verification
A register write and a qualifying error can land on the same clock edge, so the bench drives a write that clears the master enable in the very cycle a source is raised under the old, enabled value. The result is judged at the ports: halt_o must still rise, and a later read must show the written configuration together with the cause of the taken source. The cycle after, a write to a halted block is checked to have left the register untouched.

// File: rtl/checkstop_pkg.sv
package checkstop_pkg;

    // Register geometry; positions use MSB-first numbering (bit 0 = MSB).
    localparam int unsigned WORD_W     = 32;
    localparam int unsigned CE_POS     = 0;
    localparam int unsigned CAUSE_POS  = 1;
    localparam int unsigned CAUSE_MAX  = 11;
    localparam int unsigned RSV_LO_POS = 12;
    localparam int unsigned RSV_HI_POS = 14;
    localparam int unsigned EN_POS     = 15;
    localparam int unsigned EN_W       = WORD_W - EN_POS;
    localparam int unsigned MC_EN_POS  = 16;
    localparam int unsigned SRC_EN_OFS = MC_EN_POS - EN_POS;
    localparam int unsigned RST_EN_A   = 15;
    localparam int unsigned RST_EN_B   = 24;

    // Convert an MSB-first position into a vector index.
    function automatic int unsigned be_idx(input int unsigned pos);
        return WORD_W - 1 - pos;
    endfunction

    // Reset value of the enable field (index j holds position EN_POS+j).
    function automatic logic [EN_W-1:0] en_reset_vec();
        logic [EN_W-1:0] v;
        for (int unsigned j = 0; j < EN_W; j++) begin
            v[j] = ((EN_POS + j) == RST_EN_A) || ((EN_POS + j) == RST_EN_B);
        end
        return v;
    endfunction

endpackage

// File: rtl/checkstop_spr_decode.sv
module checkstop_spr_decode #(
    parameter int unsigned SPR_NUM_W = 10,
    parameter int unsigned SPR_ADDR  = 1008
) (
    input  logic                 valid_i,
    input  logic                 we_i,
    input  logic [SPR_NUM_W-1:0] num_i,
    input  logic                 sup_i,
    input  logic                 halted_i,
    output logic                 rd_hit_o,
    output logic                 wr_ok_o,
    output logic                 priv_err_o
);
    localparam logic [SPR_NUM_W-1:0] SEL = SPR_NUM_W'(SPR_ADDR);

    logic addr_hit;

    always_comb begin
        addr_hit   = valid_i && (num_i == SEL);
        rd_hit_o   = addr_hit && sup_i && !we_i;
        wr_ok_o    = addr_hit && sup_i && we_i && !halted_i;
        priv_err_o = addr_hit && !sup_i;
    end
endmodule

// File: rtl/checkstop_qualify.sv
module checkstop_qualify #(
    parameter int unsigned NUM_SRC = 11
) (
    input  logic [NUM_SRC-1:0] src_i,
    input  logic [NUM_SRC-1:0] src_en_i,
    input  logic               msr_me_i,
    input  logic               ce_i,
    input  logic               halted_i,
    output logic [NUM_SRC-1:0] qual_o,
    output logic               take_o
);
    for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
        if (k == 0) begin : g_mc
            // Machine check becomes a checkstop only with exceptions disabled.
            assign qual_o[k] = src_i[k] && src_en_i[k] && !msr_me_i;
        end else begin : g_plain
            assign qual_o[k] = src_i[k] && src_en_i[k];
        end
    end

    assign take_o = ce_i && (|qual_o) && !halted_i;
endmodule

// File: rtl/checkstop_regpack.sv
module checkstop_regpack
    import checkstop_pkg::*;
#(
    parameter int unsigned NUM_SRC = 11
) (
    input  logic               ce_i,
    input  logic [EN_W-1:0]    en_i,
    input  logic [NUM_SRC-1:0] cause_i,
    input  logic [WORD_W-1:0]  wdata_i,
    output logic [WORD_W-1:0]  word_o,
    output logic               wr_ce_o,
    output logic [EN_W-1:0]    wr_en_o
);
    localparam int unsigned CE_IDX     = be_idx(CE_POS);
    localparam int unsigned RO_HI_IDX  = be_idx(CAUSE_POS);
    localparam int unsigned RO_LO_IDX  = be_idx(RSV_HI_POS);

    logic wdata_unused;

    assign word_o[CE_IDX] = ce_i;
    assign wr_ce_o        = wdata_i[CE_IDX];

    for (genvar k = 0; k < CAUSE_MAX; k++) begin : g_cause
        localparam int unsigned IDX = be_idx(CAUSE_POS + k);
        if (k < NUM_SRC) begin : g_used
            assign word_o[IDX] = cause_i[k];
        end else begin : g_zero
            assign word_o[IDX] = 1'b0;
        end
    end

    for (genvar r = RSV_LO_POS; r <= RSV_HI_POS; r++) begin : g_rsv
        localparam int unsigned IDX = be_idx(r);
        assign word_o[IDX] = 1'b0;
    end

    for (genvar j = 0; j < EN_W; j++) begin : g_en
        localparam int unsigned IDX = be_idx(EN_POS + j);
        assign word_o[IDX] = en_i[j];
        assign wr_en_o[j]  = wdata_i[IDX];
    end

    // Cause and reserved positions are not writable.
    assign wdata_unused = ^wdata_i[RO_HI_IDX:RO_LO_IDX];
endmodule

// File: rtl/checkstop_ctrl.sv
module checkstop_ctrl
    import checkstop_pkg::*;
#(
    parameter int unsigned NUM_SRC   = 11,
    parameter int unsigned SPR_NUM_W = 10,
    parameter int unsigned SPR_ADDR  = 1008
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic [NUM_SRC-1:0]   src_i,
    input  logic                 msr_me_i,
    input  logic                 spr_valid_i,
    input  logic                 spr_we_i,
    input  logic [SPR_NUM_W-1:0] spr_num_i,
    input  logic                 spr_sup_i,
    input  logic [31:0]          spr_wdata_i,
    output logic [31:0]          spr_rdata_o,
    output logic                 priv_err_o,
    output logic                 halt_o,
    output logic                 freeze_o
);
    localparam logic [EN_W-1:0] EN_RST = en_reset_vec();

    typedef struct packed {
        logic               ce;
        logic [EN_W-1:0]    en;
        logic [NUM_SRC-1:0] cause;
        logic               halt;
        logic               freeze;
    } state_t;

    state_t state_d, state_q;

    logic               rd_hit, wr_ok, take;
    logic [NUM_SRC-1:0] qual;
    logic [WORD_W-1:0]  word_rd;
    logic               wr_ce;
    logic [EN_W-1:0]    wr_en;
    logic [EN_W:0]      cfg_view;
    logic [NUM_SRC-1:0] cause_view;

    checkstop_spr_decode #(
        .SPR_NUM_W(SPR_NUM_W),
        .SPR_ADDR (SPR_ADDR)
    ) u_decode (
        .valid_i   (spr_valid_i),
        .we_i      (spr_we_i),
        .num_i     (spr_num_i),
        .sup_i     (spr_sup_i),
        .halted_i  (state_q.halt),
        .rd_hit_o  (rd_hit),
        .wr_ok_o   (wr_ok),
        .priv_err_o(priv_err_o)
    );

    checkstop_qualify #(
        .NUM_SRC(NUM_SRC)
    ) u_qualify (
        .src_i   (src_i),
        .src_en_i(state_q.en[SRC_EN_OFS +: NUM_SRC]),
        .msr_me_i(msr_me_i),
        .ce_i    (state_q.ce),
        .halted_i(state_q.halt),
        .qual_o  (qual),
        .take_o  (take)
    );

    checkstop_regpack #(
        .NUM_SRC(NUM_SRC)
    ) u_regpack (
        .ce_i   (state_q.ce),
        .en_i   (state_q.en),
        .cause_i(state_q.cause),
        .wdata_i(spr_wdata_i),
        .word_o (word_rd),
        .wr_ce_o(wr_ce),
        .wr_en_o(wr_en)
    );

    // Next-state logic: the take decision uses the current (pre-write) state.
    always_comb begin
        state_d = state_q;
        if (wr_ok) begin
            state_d.ce = wr_ce;
            state_d.en = wr_en;
        end
        if (take) begin
            state_d.cause = state_q.cause | qual;
            state_d.halt  = 1'b1;
        end
        state_d.freeze = state_q.freeze || state_q.halt;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q.ce     <= 1'b0;
            state_q.en     <= EN_RST;
            state_q.cause  <= '0;
            state_q.halt   <= 1'b0;
            state_q.freeze <= 1'b0;
        end else begin
            state_q <= state_d;
        end
    end

    assign spr_rdata_o = rd_hit ? word_rd : '0;
    assign halt_o      = state_q.halt;
    assign freeze_o    = state_q.freeze;
    assign cfg_view    = {state_q.ce, state_q.en};
    assign cause_view  = state_q.cause;
endmodule

// File: rtl/checkstop_ctrl_chk.sv
module checkstop_ctrl_chk #(
    parameter int unsigned NUM_SRC   = 11,
    parameter int unsigned EN_W      = 17,
    parameter int unsigned SPR_NUM_W = 10,
    parameter int unsigned SPR_ADDR  = 1008
) (
    input logic                 clk_i,
    input logic                 rst_ni,
    input logic                 halt_o,
    input logic                 freeze_o,
    input logic                 priv_err_o,
    input logic                 spr_valid_i,
    input logic [SPR_NUM_W-1:0] spr_num_i,
    input logic [31:0]          word_rd,
    input logic [EN_W:0]        cfg_view,
    input logic [NUM_SRC-1:0]   cause_view
);
    localparam logic [SPR_NUM_W-1:0] SEL = SPR_NUM_W'(SPR_ADDR);

    // R1: a disabled master enable keeps the core running
    assert_no_take_disabled_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!halt_o && !cfg_view[EN_W]) |=> !halt_o);

    // R3: freeze follows halt by one cycle
    assert_freeze_after_halt_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(halt_o) |=> freeze_o);

    // R3: halt is held until reset
    assert_halt_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        halt_o |=> halt_o);

    // R3: freeze only exists with halt
    assert_freeze_needs_halt_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        freeze_o |-> halt_o);

    // R4: a cause bit only appears when the checkstop is taken
    assert_cause_on_take_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|(cause_view & ~$past(cause_view))) |-> $rose(halt_o));

    // R8: foreign register numbers leave the configuration alone
    assert_other_num_ignored_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (spr_valid_i && (spr_num_i != SEL)) |=> $stable(cfg_view));

    // R9: a user-privilege access changes nothing
    assert_user_no_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        priv_err_o |=> $stable(cfg_view));

    // R10: the register is locked once frozen
    assert_frozen_locked_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        freeze_o |=> $stable(word_rd));
endmodule

bind checkstop_ctrl checkstop_ctrl_chk #(
    .NUM_SRC  (NUM_SRC),
    .EN_W     (checkstop_pkg::EN_W),
    .SPR_NUM_W(SPR_NUM_W),
    .SPR_ADDR (SPR_ADDR)
) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .halt_o     (halt_o),
    .freeze_o   (freeze_o),
    .priv_err_o (priv_err_o),
    .spr_valid_i(spr_valid_i),
    .spr_num_i  (spr_num_i),
    .word_rd    (word_rd),
    .cfg_view   (cfg_view),
    .cause_view (cause_view)
);

// File: tb/test_checkstop_ctrl.sv
module test_checkstop_ctrl;
    localparam int NSRC = 11;
    localparam logic [31:0] RST_WORD = 32'h0001_0080;

    typedef struct packed {
        logic            ce;
        logic [NSRC-1:0] mask;
        logic [NSRC-1:0] src;
        logic            me;
        logic            exp_halt;
        logic [NSRC-1:0] exp_cause;
    } vec_t;

    // mask/src/cause: bit k = source k (cause bit 1+k, enable bit 16+k)
    localparam vec_t VECS[8] = '{
        '{1'b1, 11'h7FF, 11'h004, 1'b0, 1'b1, 11'h004},  // R2 single source
        '{1'b0, 11'h7FF, 11'h7FF, 1'b0, 1'b0, 11'h000},  // R1 master off
        '{1'b1, 11'h7F7, 11'h008, 1'b0, 1'b0, 11'h000},  // R2 masked source
        '{1'b1, 11'h7DF, 11'h0A8, 1'b0, 1'b1, 11'h088},  // R4 several, one masked
        '{1'b1, 11'h7FF, 11'h001, 1'b0, 1'b1, 11'h001},  // R5 machine check taken
        '{1'b1, 11'h7FF, 11'h001, 1'b1, 1'b0, 11'h000},  // R5 exceptions on
        '{1'b1, 11'h7FE, 11'h001, 1'b0, 1'b0, 11'h000},  // R5 bit 16 clear
        '{1'b1, 11'h7FF, 11'h401, 1'b1, 1'b1, 11'h400}   // R5 with other source
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] src = '0;
    logic            me = 1'b0;
    logic            valid = 1'b0;
    logic            we = 1'b0;
    logic [9:0]      num = '0;
    logic            sup = 1'b0;
    logic [31:0]     wdata = '0;
    logic [31:0]     rdata;
    logic            perr, halt, freeze;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    checkstop_ctrl i_checkstop_ctrl (
        .clk_i(clk), .rst_ni(rst_n), .src_i(src), .msr_me_i(me),
        .spr_valid_i(valid), .spr_we_i(we), .spr_num_i(num), .spr_sup_i(sup),
        .spr_wdata_i(wdata), .spr_rdata_o(rdata), .priv_err_o(perr),
        .halt_o(halt), .freeze_o(freeze)
    );

    function automatic logic [31:0] mk_cfg(input logic ce, input logic [NSRC-1:0] mask);
        logic [31:0] w = '0;
        w[31] = ce;
        w[16] = 1'b1;
        for (int k = 0; k < NSRC; k++) w[15-k] = mask[k];
        return w;
    endfunction

    function automatic logic [31:0] add_cause(input logic [31:0] w, input logic [NSRC-1:0] c);
        logic [31:0] r = w;
        for (int k = 0; k < NSRC; k++) r[30-k] = r[30-k] | c[k];
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic spr_write(input logic [9:0] n, input logic s, input logic [31:0] d);
        @(negedge clk);
        valid = 1'b1; we = 1'b1; num = n; sup = s; wdata = d;
        @(posedge clk);
        #1;
        valid = 1'b0; we = 1'b0; wdata = '0;
    endtask

    task automatic spr_read(input logic [9:0] n, input logic s, output logic [31:0] d, output logic pe);
        @(negedge clk);
        valid = 1'b1; we = 1'b0; num = n; sup = s;
        #1;
        d = rdata;
        pe = perr;
        valid = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic        pe;

        // Reset state
        do_reset();
        spr_read(10'd1008, 1'b1, d, pe);
        check(d == RST_WORD, "R6 reset word", d, RST_WORD);
        check(!halt && !freeze, "R6 outputs low", {30'b0, halt, freeze}, 32'h0);

        // Vector table
        for (int i = 0; i < 8; i++) begin
            logic [31:0] cfg;
            do_reset();
            cfg = mk_cfg(VECS[i].ce, VECS[i].mask);
            spr_write(10'd1008, 1'b1, cfg);
            spr_read(10'd1008, 1'b1, d, pe);
            check(d == cfg, "R7 write readback", d, cfg);
            @(negedge clk);
            src = VECS[i].src; me = VECS[i].me;
            @(posedge clk);
            @(negedge clk);
            src = '0; me = 1'b0;
            check(halt == VECS[i].exp_halt, "R2 halt after sample", {31'b0, halt}, {31'b0, VECS[i].exp_halt});
            check(freeze == 1'b0, "R3 no freeze yet", {31'b0, freeze}, 32'h0);
            @(negedge clk);
            check(freeze == VECS[i].exp_halt, "R3 freeze one cycle later", {31'b0, freeze}, {31'b0, VECS[i].exp_halt});
            spr_read(10'd1008, 1'b1, d, pe);
            check(d == add_cause(cfg, VECS[i].exp_cause), "R4 cause capture", d, add_cause(cfg, VECS[i].exp_cause));
        end

        // Reserved and cause positions are not writable
        do_reset();
        spr_write(10'd1008, 1'b1, 32'hFFFF_FFFF);
        spr_read(10'd1008, 1'b1, d, pe);
        check(d == 32'h8001_FFFF, "R7 reserved and causes read 0", d, 32'h8001_FFFF);

        // User privilege access
        do_reset();
        @(negedge clk);
        valid = 1'b1; we = 1'b1; num = 10'd1008; sup = 1'b0; wdata = 32'hFFFF_FFFF;
        #1;
        check(perr == 1'b1, "R9 priv_err on user write", {31'b0, perr}, 32'h1);
        check(rdata == 32'h0, "R9 no data to user", rdata, 32'h0);
        @(posedge clk);
        #1;
        valid = 1'b0; we = 1'b0; wdata = '0;
        spr_read(10'd1008, 1'b0, d, pe);
        check(pe == 1'b1 && d == 32'h0, "R9 user read", d, 32'h0);
        spr_read(10'd1008, 1'b1, d, pe);
        check(d == RST_WORD && pe == 1'b0, "R9 register unchanged", d, RST_WORD);

        // Other register numbers
        spr_write(10'd1007, 1'b1, 32'hFFFF_FFFF);
        spr_read(10'd1007, 1'b1, d, pe);
        check(d == 32'h0 && pe == 1'b0, "R8 other number reads 0", d, 32'h0);
        spr_read(10'd1008, 1'b1, d, pe);
        check(d == RST_WORD, "R8 other number no write", d, RST_WORD);

        // Write and checkstop on the same edge
        spr_write(10'd1008, 1'b1, mk_cfg(1'b1, 11'h7FF));
        @(negedge clk);
        src = 11'h004;
        valid = 1'b1; we = 1'b1; num = 10'd1008; sup = 1'b1; wdata = mk_cfg(1'b0, 11'h7FF);
        @(posedge clk);
        #1;
        valid = 1'b0; we = 1'b0; wdata = '0; src = '0;
        @(negedge clk);
        check(halt == 1'b1, "R11 take uses old enable", {31'b0, halt}, 32'h1);
        spr_read(10'd1008, 1'b1, d, pe);
        check(d == add_cause(mk_cfg(1'b0, 11'h7FF), 11'h004), "R11 write also applied", d,
              add_cause(mk_cfg(1'b0, 11'h7FF), 11'h004));

        // Later sources and writes after checkstop
        @(negedge clk);
        src = 11'h010;
        @(negedge clk);
        src = '0;
        spr_write(10'd1008, 1'b1, 32'h0);
        spr_read(10'd1008, 1'b1, d, pe);
        check(d == add_cause(mk_cfg(1'b0, 11'h7FF), 11'h004), "R10 write ignored, R4 cause unchanged", d,
              add_cause(mk_cfg(1'b0, 11'h7FF), 11'h004));
        repeat (4) @(negedge clk);
        check(halt && freeze, "R3 held until reset", {30'b0, halt, freeze}, 32'h3);

        // Reset leaves checkstop
        do_reset();
        spr_read(10'd1008, 1'b1, d, pe);
        check(!halt && !freeze && d == RST_WORD, "R6 reset clears checkstop", d, RST_WORD);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule